// File: doc/BRIEF.md
# Unified data-space access unit

This block lets one requester reach three storage targets through a single 8-bit data address. The lowest 32 addresses reach a general register file, and the register number is the address itself. The next 64 addresses reach a window of I/O stub registers. The 128 addresses after those reach an internal SRAM. The top 32 addresses decode to no target. The requester drives an address, a read strobe, a write strobe and write data. The unit decodes the address, turns it into the target's local index and returns read data with a one-cycle valid pulse.

Register-file and I/O accesses finish in the cycle they are presented. An SRAM access takes two cycles. In the first cycle the unit latches the SRAM index and raises `stall`, and the requester holds its request for one more cycle. In the second cycle the write data is taken or the read data is captured. The register file also has two operand read ports that are independent of the bus, so an ALU can read two source registers while the bus write port updates a destination. Everything runs from one clock, and reset is synchronous.

The control is a two-state machine:
- `ST_IDLE` accepts a new request. An SRAM hit takes the transition "sram start" to `ST_SRAM_DATA`. Every other case takes "stay idle".
- `ST_SRAM_DATA` always takes the transition "sram finish" back to `ST_IDLE`.

Top module: `dspace_unit`

## Requirements
- R1: Addresses 0x00 to 0x1F reach general register index = address. A read returns the stored byte with `rd_valid` high for exactly the cycle after the request cycle.
- R2: Addresses 0x20 to 0x5F reach I/O stub index = address − 0x20. This storage is separate from the register file, so writing 0x20 leaves register 0 and register 31 unchanged.
- R3: Addresses 0x60 to 0xDF reach SRAM index = address − 0x60. 0x5F and 0x60 hold separate bytes, and 0xDF is the last SRAM byte.
- R4: An SRAM access raises `stall` in its first cycle only. Write data is taken in the second cycle, so the value on `req_wdata` in the first cycle is discarded. For an SRAM read, `rd_valid` rises two cycles after the first request cycle.
- R5: Register-file and I/O accesses never raise `stall`.
- R6: `opa_data` and `opb_data` show the register entries selected by `opa_idx` and `opb_idx` at the same moment. Both reflect a bus write from the cycle after that write.
- R7: For addresses 0xE0 to 0xFF:
  - a write changes no storage;
  - a read returns 0x00 with `rd_valid` set;
  - `oor_flag` is high for exactly the cycle after each such access.
- R8: A request with read and write both high acts as a write only: the data is stored and `rd_valid` stays low.
- R9: Synchronous reset behaves as follows:
  - it clears every register-file and I/O entry to 0x00;
  - it forces `rd_data` to 0x00 and `rd_valid`, `stall` and `oor_flag` to 0;
  - it leaves SRAM contents unchanged.
- R10: `rd_data` holds the last value read until the next read finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | 8 | Data-space address |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe (wins over read) |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| stall | output | 1 | First cycle of an SRAM access; hold the request |
| oor_flag | output | 1 | Pulse after an access to 0xE0–0xFF |
| opa_idx | input | 5 | Operand A register index |
| opb_idx | input | 5 | Operand B register index |
| opa_data | output | 8 | Operand A register contents |
| opb_data | output | 8 | Operand B register contents |

## Verification
The bench builds the unit with its default sizes: 32 registers, 64 I/O registers and 128 SRAM bytes. With these sizes the whole 8-bit address space is decoded, so the three region seams (0x1F/0x20, 0x5F/0x60, 0xDF/0xE0) can be checked, along with both ends of the empty 0xE0–0xFF region. A scoreboard compares each read result against a byte model of the address space. Direct checks at the ports cover `stall` and `oor_flag` timing, rejection of first-cycle write data on SRAM writes, the rule that a write wins over a read, and SRAM retention across reset.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    typedef enum logic [1:0] {
        TGT_RF   = 2'd0,
        TGT_IO   = 2'd1,
        TGT_SRAM = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_SRAM_DATA = 1'b1
    } st_e;

endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
    import dspace_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RF_DEPTH   = 32,
    parameter int IO_DEPTH   = 64,
    parameter int SRAM_DEPTH = 128,
    localparam int RF_IW     = $clog2(RF_DEPTH),
    localparam int IO_IW     = $clog2(IO_DEPTH),
    localparam int SR_IW     = $clog2(SRAM_DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [RF_IW-1:0]  rf_idx,
    output logic [IO_IW-1:0]  io_idx,
    output logic [SR_IW-1:0]  sram_idx
);
    localparam int IO_BASE   = RF_DEPTH;
    localparam int SRAM_BASE = RF_DEPTH + IO_DEPTH;
    localparam int SPACE_END = SRAM_BASE + SRAM_DEPTH;

    always_comb begin
        if (int'(addr) < IO_BASE)
            tgt = TGT_RF;
        else if (int'(addr) < SRAM_BASE)
            tgt = TGT_IO;
        else if (int'(addr) < SPACE_END)
            tgt = TGT_SRAM;
        else
            tgt = TGT_NONE;
    end

    assign rf_idx   = RF_IW'(addr);
    assign io_idx   = IO_IW'(addr - ADDR_W'(IO_BASE));
    assign sram_idx = SR_IW'(addr - ADDR_W'(SRAM_BASE));

endmodule

// File: rtl/dspace_regfile.sv
module dspace_regfile #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    parameter int NRD    = 3,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IW-1:0]               waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NRD-1:0][IW-1:0]      raddr,
    output logic [NRD-1:0][DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

    // R1 / R2: an accepted write is present in storage on the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dspace_sram.sv
module dspace_sram #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/dspace_unit.sv
module dspace_unit
    import dspace_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int RF_DEPTH   = 32,
    parameter int IO_DEPTH   = 64,
    parameter int SRAM_DEPTH = 128,
    localparam int RF_IW     = $clog2(RF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              stall,
    output logic              oor_flag,
    input  logic [RF_IW-1:0]  opa_idx,
    input  logic [RF_IW-1:0]  opb_idx,
    output logic [DATA_W-1:0] opa_data,
    output logic [DATA_W-1:0] opb_data
);
    localparam int IO_IW = $clog2(IO_DEPTH);
    localparam int SR_IW = $clog2(SRAM_DEPTH);

    st_e                  state, state_nxt;
    tgt_e                 tgt;
    logic [RF_IW-1:0]     rf_idx;
    logic [IO_IW-1:0]     io_idx;
    logic [SR_IW-1:0]     sram_idx, lat_idx;
    logic                 lat_rd, lat_wr;
    logic                 acc, do_rd;
    logic                 rf_we, io_we, sram_we;
    logic [2:0][DATA_W-1:0] rf_q;
    logic [DATA_W-1:0]    io_q, sram_q;

    assign acc   = req_rd | req_wr;
    assign do_rd = req_rd & ~req_wr;

    dspace_decode #(
        .ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH),
        .IO_DEPTH(IO_DEPTH), .SRAM_DEPTH(SRAM_DEPTH)
    ) u_decode (
        .addr(req_addr), .tgt(tgt), .rf_idx(rf_idx),
        .io_idx(io_idx), .sram_idx(sram_idx)
    );

    dspace_regfile #(.DEPTH(RF_DEPTH), .DATA_W(DATA_W), .NRD(3)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_idx), .wdata(req_wdata),
        .raddr({opb_idx, opa_idx, rf_idx}), .rdata(rf_q)
    );

    dspace_regfile #(.DEPTH(IO_DEPTH), .DATA_W(DATA_W), .NRD(1)) u_io (
        .clk(clk), .rst(rst), .we(io_we), .waddr(io_idx), .wdata(req_wdata),
        .raddr(io_idx), .rdata(io_q)
    );

    dspace_sram #(.DEPTH(SRAM_DEPTH), .DATA_W(DATA_W)) u_sram (
        .clk(clk), .we(sram_we), .addr(lat_idx), .wdata(req_wdata),
        .rdata(sram_q)
    );

    assign opa_data = rf_q[1];
    assign opb_data = rf_q[2];

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // next state and strobes
    always_comb begin
        state_nxt = state;
        stall     = 1'b0;
        rf_we     = 1'b0;
        io_we     = 1'b0;
        sram_we   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                rf_we = req_wr && (tgt == TGT_RF);
                io_we = req_wr && (tgt == TGT_IO);
                if (acc && tgt == TGT_SRAM) begin
                    stall     = 1'b1;
                    state_nxt = ST_SRAM_DATA;
                end
            end
            ST_SRAM_DATA: begin
                sram_we   = lat_wr;
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // registered outputs and SRAM latch
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            oor_flag <= 1'b0;
            lat_idx  <= '0;
            lat_rd   <= 1'b0;
            lat_wr   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            oor_flag <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (acc) begin
                        unique case (tgt)
                            TGT_RF: if (do_rd) begin
                                rd_data  <= rf_q[0];
                                rd_valid <= 1'b1;
                            end
                            TGT_IO: if (do_rd) begin
                                rd_data  <= io_q;
                                rd_valid <= 1'b1;
                            end
                            TGT_SRAM: begin
                                lat_idx <= sram_idx;
                                lat_rd  <= do_rd;
                                lat_wr  <= req_wr;
                            end
                            TGT_NONE: begin
                                oor_flag <= 1'b1;
                                if (do_rd) begin
                                    rd_data  <= '0;
                                    rd_valid <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_SRAM_DATA: begin
                    if (lat_rd) begin
                        rd_data  <= sram_q;
                        rd_valid <= 1'b1;
                    end
                    lat_rd <= 1'b0;
                    lat_wr <= 1'b0;
                end
            endcase
        end
    end

    // R4: stall never lasts two cycles in a row
    a_r4_stall_single: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R4: SRAM read result appears two cycles after the first cycle
    a_r4_sram_read_latency: assert property (@(posedge clk) disable iff (rst)
        (stall && req_rd && !req_wr) |=> ##1 rd_valid);

    // R7: out-of-range access flags on the next cycle
    a_r7_oor_pulse: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && acc && tgt == TGT_NONE) |=> oor_flag);

    // R8: combined read and write to a one-cycle target returns nothing
    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_rd && req_wr && tgt != TGT_SRAM) |=> !rd_valid);

    // R5: one-cycle targets never stall
    a_r5_no_stall: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (tgt == TGT_RF || tgt == TGT_IO)) |-> !stall);

endmodule

// File: tb/dspace_unit_tb.sv
`timescale 1ns/1ps
module dspace_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_addr = '0;
    logic       req_rd = 1'b0, req_wr = 1'b0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rd_data;
    logic       rd_valid, stall, oor_flag;
    logic [4:0] opa_idx = '0, opb_idx = '0;
    logic [7:0] opa_data, opb_data;

    always #5 clk = ~clk;

    dspace_unit u_dut (
        .clk(clk), .rst(rst), .req_addr(req_addr), .req_rd(req_rd),
        .req_wr(req_wr), .req_wdata(req_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .stall(stall), .oor_flag(oor_flag),
        .opa_idx(opa_idx), .opb_idx(opb_idx),
        .opa_data(opa_data), .opb_data(opb_data)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] data;
        string      req;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] model [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_sram(input logic [7:0] a);
        return (a >= 8'h60 && a <= 8'hDF);
    endfunction

    // monitor: pops the scoreboard on each read result
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8 unexpected rd_valid", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(rd_data == it.data, it.req, rd_data, it.data);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input string req);
        @(posedge clk); #1;
        req_addr = a; req_wr = 1'b1; req_rd = 1'b0;
        req_wdata = in_sram(a) ? ~d : d;
        #4;
        chk(stall == in_sram(a), in_sram(a) ? "R4 stall first cycle" : "R5 no stall",
            stall, in_sram(a));
        if (in_sram(a)) begin
            @(posedge clk); #1;
            req_wdata = d;
            #4;
            chk(stall == 1'b0, "R4 stall second cycle", stall, 0);
        end
        @(posedge clk); #1;
        req_wr = 1'b0;
        if (a < 8'hE0) model[a] = d;
        #4;
        if (a >= 8'hE0) chk(oor_flag == 1'b1, "R7 oor flag on write", oor_flag, 1);
        else            chk(oor_flag == 1'b0, req, oor_flag, 0);
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        item_t it;
        it.addr = a;
        it.data = (a >= 8'hE0) ? 8'h00 : model[a];
        it.req  = req;
        @(posedge clk); #1;
        req_addr = a; req_rd = 1'b1; req_wr = 1'b0;
        sb_q.push_back(it);
        #4;
        chk(stall == in_sram(a), in_sram(a) ? "R4 stall on read" : "R5 no stall on read",
            stall, in_sram(a));
        if (in_sram(a)) begin
            @(posedge clk); #1;
            #4;
            chk(rd_valid == 1'b0, "R4 no early read result", rd_valid, 0);
        end
        @(posedge clk); #1;
        req_rd = 1'b0;
        #4;
        if (a >= 8'hE0) begin
            chk(oor_flag == 1'b1, "R7 oor flag on read", oor_flag, 1);
            @(negedge clk);
            chk(oor_flag == 1'b0, "R7 oor flag one cycle", oor_flag, 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;

        // reset state, R9
        repeat (3) @(posedge clk);
        #4;
        chk(rd_data == 8'h00, "R9 reset rd_data", rd_data, 0);
        chk(rd_valid == 1'b0, "R9 reset rd_valid", rd_valid, 0);
        chk(stall == 1'b0, "R9 reset stall", stall, 0);
        chk(oor_flag == 1'b0, "R9 reset oor_flag", oor_flag, 0);
        @(posedge clk); #1 rst = 1'b0;

        // R1 register file
        for (int i = 0; i < 32; i++) bus_write(8'(i), 8'(i * 7 + 3), "R1 rf write");
        bus_read(8'h00, "R1 read r0");
        bus_read(8'h11, "R1 read r17");
        bus_read(8'h1F, "R1 read r31");

        // R2 I/O window, separate from registers
        bus_write(8'h20, 8'hC1, "R2 io write low");
        bus_write(8'h5F, 8'hC2, "R2 io write high");
        bus_write(8'h3A, 8'hC3, "R2 io write mid");
        bus_read(8'h20, "R2 read io 0");
        bus_read(8'h5F, "R2 read io 63");
        bus_read(8'h3A, "R2 read io 26");
        bus_read(8'h00, "R2 r0 untouched by io");
        bus_read(8'h1F, "R2 r31 untouched by io");

        // R3 / R4 SRAM with first-cycle junk data
        bus_write(8'h60, 8'hA0, "R3 sram write first");
        bus_write(8'hDF, 8'hA1, "R3 sram write last");
        bus_write(8'h9B, 8'hA2, "R3 sram write mid");
        bus_read(8'h60, "R4 sram read first");
        bus_read(8'hDF, "R4 sram read last");
        bus_read(8'h9B, "R4 sram read mid");
        bus_read(8'h5F, "R3 io 63 separate from sram");

        // R6 operand ports
        bus_write(8'h03, 8'h33, "R6 set r3");
        bus_write(8'h1E, 8'hA5, "R6 set r30");
        opa_idx = 5'd3; opb_idx = 5'd30;
        @(negedge clk);
        chk(opa_data == 8'h33, "R6 opa", opa_data, 8'h33);
        chk(opb_data == 8'hA5, "R6 opb", opb_data, 8'hA5);
        opa_idx = 5'd31; opb_idx = 5'd0;
        @(negedge clk);
        chk(opa_data == model[31], "R6 opa r31", opa_data, model[31]);
        chk(opb_data == model[0], "R6 opb r0", opb_data, model[0]);

        // R7 out-of-range
        bus_write(8'hE0, 8'h55, "R7 oor write low");
        bus_write(8'hFF, 8'h66, "R7 oor write high");
        bus_read(8'hE0, "R7 oor read low");
        bus_read(8'hFF, "R7 oor read high");
        bus_read(8'h00, "R7 no wrap into r0");
        bus_read(8'h60, "R7 no effect on sram");

        // R10 rd_data holds between reads
        repeat (3) @(negedge clk);
        chk(rd_data == model[8'h60], "R10 rd_data hold", rd_data, model[8'h60]);

        // R8 read+write acts as write
        @(posedge clk); #1;
        req_addr = 8'h05; req_rd = 1'b1; req_wr = 1'b1; req_wdata = 8'h9E;
        @(posedge clk); #1;
        req_rd = 1'b0; req_wr = 1'b0;
        model[8'h05] = 8'h9E;
        #4;
        chk(rd_valid == 1'b0, "R8 no read result", rd_valid, 0);
        bus_read(8'h05, "R8 data written");

        // R9 reset clears rf/io, keeps sram
        bus_write(8'h70, 8'h5A, "R9 sram before reset");
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 8'h60; i++) model[i] = 8'h00;
        bus_read(8'h05, "R9 rf cleared");
        bus_read(8'h3A, "R9 io cleared");
        bus_read(8'h70, "R9 sram retained");

        repeat (4) @(posedge clk);
        chk(sb_q.size() == 0, "R1 all reads returned", sb_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule